// File: doc/BRIEF.md
# Four-Channel Down-Counting Timer

This peripheral holds four independent decrementing counters behind a plain register bus with an address, write data, a write strobe and read data. A single input tick is the time base for every channel. Each channel divides that tick by 1, 16 or 256 and then decrements its count by one on each divided tick. A channel counts 16 or 32 bits wide. Its reload on underflow comes either from a background register (periodic) or from the top of its range (free-running). In one-shot mode the counter instead halts at zero.

Every channel reports its underflows into one shared raw-status vector. A mask selects which of those bits may drive the single interrupt line. Software acknowledges an event by writing ones to a clear register. Reads are combinational, so read data follows the address in the same cycle. Writes take effect at the clock edge on which the strobe is sampled.

Top module: `tmr_unit`

## Requirements
- R1: After a synchronous reset, every readable register is zero, every counter is zero and disabled, and irq is low.
- R2: Byte-address map: 0x00 is the mask (read/write), 0x04 is the raw status (read-only), 0x08 is the masked status (read-only) and 0x0C is the clear register. Channel n occupies 0x10+0x10*n, with +0x0 load (read/write), +0x4 current value (read-only), +0x8 control and +0xC background reload. Misaligned, unmapped and read-only writes are ignored, and misaligned or unmapped reads return zero.
- R3: Control word layout: bit 7 enable, bit 6 periodic, bits 3:2 prescale code, bit 1 selects 32-bit width, bit 0 one-shot. The other bits read as zero.
- R4: A write to load sets the counter at once to the written value, masked to the current width. It also copies the value into the background register and restarts the prescaler. A write to load or control also restarts the prescaler and takes no counting step in that cycle.
- R5: With enable set, each divided tick lowers the count by one. With enable clear, the count holds.
- R6: Prescale code 00 steps on every tick, 01 on every 16th tick and 10 on every 256th tick, counted from the last load or control write. Code 11 acts as 00.
- R7: With bit 1 clear, the value reads as its low 16 bits and a free-running wrap goes to 0xFFFF. With bit 1 set, a free-running wrap goes to 0xFFFFFFFF.
- R8: An underflow is a step taken while the value is zero. In periodic mode (bit 6 set) the counter then reloads from the background register. Otherwise it wraps to the top of its width.
- R9: A write to the background register leaves the running count untouched. The new value is used at the next underflow.
- R10: In one-shot mode (bit 0 set), the underflow step raises status, and the counter stays at zero and stops. Only a load or control write restarts it.
- R11: Each underflow sets the channel's raw bit (bit n for channel n). Masked status is raw AND mask, and irq is the OR of the masked bits.
- R12: Writing a 1 to a clear-register bit clears that raw bit, and writing 0 leaves it unchanged. The clear register reads as zero. An underflow in the same cycle as its clear leaves the bit set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Count time base, one pulse per clock when high |
| bus_addr | input | 8 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_we | input | 1 | Write strobe, sampled at the clock edge |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| irq | output | 1 | Interrupt, OR of masked status |

## Verification
Read data is combinational, so a register value, count or status bit can be read the same cycle it is addressed. A write changes state at the edge that samples bus_we, and a tick sampled at an edge changes the count and the raw bit at that same edge. irq follows raw and mask with no register delay. The bench therefore drives each input 2 ns after a rising edge and reads 1 ns later, which is after the edge that applied the stimulus and before the next one. Prescaled cases are checked one tick short of the divide boundary and again one tick after it.

// File: rtl/tmr_pkg.sv
`timescale 1ns/1ps
package tmr_pkg;
    localparam int DATA_W = 32;
    localparam int PRE_W  = 8;

    localparam logic [1:0] SUB_LOAD = 2'd0;
    localparam logic [1:0] SUB_VAL  = 2'd1;
    localparam logic [1:0] SUB_CTL  = 2'd2;
    localparam logic [1:0] SUB_BG   = 2'd3;

    typedef enum logic [1:0] {
        PS_DIV1   = 2'b00,
        PS_DIV16  = 2'b01,
        PS_DIV256 = 2'b10,
        PS_RSVD   = 2'b11
    } psel_e;

    typedef struct packed {
        logic  en;
        logic  periodic;
        psel_e psel;
        logic  wide;
        logic  oneshot;
    } ctrl_t;

    typedef enum logic [3:0] {
        SEL_NONE,
        SEL_MASK,
        SEL_RAW,
        SEL_MIS,
        SEL_CLR,
        SEL_LOAD,
        SEL_VAL,
        SEL_CTL,
        SEL_BG
    } sel_e;

    function automatic ctrl_t ctrl_from_word(input logic [DATA_W-1:0] w);
        ctrl_t c;
        c.en       = w[7];
        c.periodic = w[6];
        c.psel     = psel_e'(w[3:2]);
        c.wide     = w[1];
        c.oneshot  = w[0];
        return c;
    endfunction

    function automatic logic [DATA_W-1:0] ctrl_to_word(input ctrl_t c);
        return {{(DATA_W-8){1'b0}}, c.en, c.periodic, 2'b00,
                c.psel, c.wide, c.oneshot};
    endfunction

    function automatic logic [PRE_W-1:0] pre_last(input psel_e p);
        case (p)
            PS_DIV16:  return PRE_W'(15);
            PS_DIV256: return PRE_W'(255);
            default:   return '0;
        endcase
    endfunction

    function automatic logic [DATA_W-1:0] width_mask(input logic wide);
        return wide ? {DATA_W{1'b1}} : {{(DATA_W-16){1'b0}}, 16'hFFFF};
    endfunction
endpackage

// File: rtl/tmr_addr_dec.sv
`timescale 1ns/1ps
module tmr_addr_dec
    import tmr_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int NUM_CH = 4,
    parameter int CH_W   = 2
) (
    input  logic [ADDR_W-1:0] addr,
    output sel_e              sel,
    output logic [CH_W-1:0]   idx
);
    localparam int SLOT_W = ADDR_W - 4;
    localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(NUM_CH);

    logic [SLOT_W-1:0] slot;
    assign slot = addr[ADDR_W-1:4];

    always_comb begin
        sel = SEL_NONE;
        idx = '0;
        if (addr[1:0] == 2'b00) begin
            if (slot == '0) begin
                case (addr[3:2])
                    2'd0:    sel = SEL_MASK;
                    2'd1:    sel = SEL_RAW;
                    2'd2:    sel = SEL_MIS;
                    default: sel = SEL_CLR;
                endcase
            end else if (slot <= LAST_SLOT) begin
                idx = CH_W'(slot - SLOT_W'(1));
                case (addr[3:2])
                    SUB_LOAD: sel = SEL_LOAD;
                    SUB_VAL:  sel = SEL_VAL;
                    SUB_CTL:  sel = SEL_CTL;
                    default:  sel = SEL_BG;
                endcase
            end
        end
    end
endmodule

// File: rtl/tmr_prescale.sv
`timescale 1ns/1ps
module tmr_prescale
    import tmr_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  restart,
    input  logic  tick,
    input  logic  run,
    input  psel_e psel,
    output logic  stb
);
    logic [PRE_W-1:0] pre_cnt;
    logic [PRE_W-1:0] last;
    logic             hit;

    assign last = pre_last(psel);
    assign hit  = (pre_cnt == last);
    assign stb  = tick && run && !restart && hit;

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            pre_cnt <= '0;
        end else if (tick && run) begin
            pre_cnt <= hit ? '0 : pre_cnt + PRE_W'(1);
        end
    end

    AST_PRE_BOUND: assert property (@(posedge clk) disable iff (rst)
        (tick && run && !restart && !hit) |=> (pre_cnt != '0)); // R6
endmodule

// File: rtl/tmr_chan.sv
`timescale 1ns/1ps
module tmr_chan
    import tmr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              ld_we,
    input  logic              ctl_we,
    input  logic              bg_we,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] ld_q,
    output logic [DATA_W-1:0] bg_q,
    output logic [DATA_W-1:0] val,
    output ctrl_t             ctrl_q,
    output logic              uf
);
    logic [DATA_W-1:0] cnt;
    logic [DATA_W-1:0] mask;
    logic [DATA_W-1:0] cnt_m;
    logic              halted;
    logic              at_zero;
    logic              stb;

    assign mask    = width_mask(ctrl_q.wide);
    assign cnt_m   = cnt & mask;
    assign at_zero = (cnt_m == '0);
    assign val     = cnt_m;
    assign uf      = stb && at_zero;

    tmr_prescale u_pre (
        .clk     (clk),
        .rst     (rst),
        .restart (ld_we || ctl_we),
        .tick    (tick),
        .run     (ctrl_q.en && !halted),
        .psel    (ctrl_q.psel),
        .stb     (stb)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt    <= '0;
            ld_q   <= '0;
            bg_q   <= '0;
            ctrl_q <= '0;
            halted <= 1'b0;
        end else begin
            if (ld_we) begin
                ld_q   <= wdata;
                bg_q   <= wdata;
                cnt    <= wdata & mask;
                halted <= 1'b0;
            end else begin
                if (bg_we) begin
                    bg_q <= wdata;
                end
                if (stb) begin
                    if (!at_zero) begin
                        cnt <= cnt_m - DATA_W'(1);
                    end else if (ctrl_q.oneshot) begin
                        halted <= 1'b1;
                    end else if (ctrl_q.periodic) begin
                        cnt <= bg_q & mask;
                    end else begin
                        cnt <= mask;
                    end
                end
            end
            if (ctl_we) begin
                ctrl_q <= ctrl_from_word(wdata);
                halted <= 1'b0;
            end
        end
    end

    AST_HOLD_DISABLED: assert property (@(posedge clk) disable iff (rst)
        (!ctrl_q.en && !ld_we) |=> $stable(cnt)); // R5
    AST_STEP_DOWN: assert property (@(posedge clk) disable iff (rst)
        (stb && !at_zero) |=> (val == $past(cnt_m) - DATA_W'(1))); // R5
    AST_BG_NO_DISTURB: assert property (@(posedge clk) disable iff (rst)
        (bg_we && !stb && !ld_we) |=> $stable(cnt)); // R9
    AST_ONESHOT_STOP: assert property (@(posedge clk) disable iff (rst)
        (halted && !ld_we && !ctl_we) |=> ($stable(cnt) && halted)); // R10
endmodule

// File: rtl/tmr_irq.sv
`timescale 1ns/1ps
module tmr_irq #(
    parameter int NUM_CH = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NUM_CH-1:0] set,
    input  logic              mask_we,
    input  logic              clr_we,
    input  logic [NUM_CH-1:0] wbits,
    output logic [NUM_CH-1:0] mask_q,
    output logic [NUM_CH-1:0] raw_q,
    output logic [NUM_CH-1:0] mis,
    output logic              irq
);
    logic [NUM_CH-1:0] clr_bits;

    assign clr_bits = clr_we ? wbits : '0;
    assign mis      = raw_q & mask_q;
    assign irq      = |mis;

    always_ff @(posedge clk) begin
        if (rst) begin
            mask_q <= '0;
            raw_q  <= '0;
        end else begin
            if (mask_we) begin
                mask_q <= wbits;
            end
            raw_q <= (raw_q & ~clr_bits) | set;
        end
    end

    AST_RAW_SET: assert property (@(posedge clk) disable iff (rst)
        (|set) |=> ((raw_q & $past(set)) == $past(set))); // R11
    AST_CLEAR_WORKS: assert property (@(posedge clk) disable iff (rst)
        clr_we |=> ((raw_q & $past(wbits & ~set)) == '0)); // R12
    AST_RAW_STICKY: assert property (@(posedge clk) disable iff (rst)
        (!clr_we) |=> ((raw_q & $past(raw_q)) == $past(raw_q))); // R11
endmodule

// File: rtl/tmr_unit.sv
`timescale 1ns/1ps
module tmr_unit
    import tmr_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    input  logic              bus_we,
    output logic [31:0]       bus_rdata,
    output logic              irq
);
    localparam int CH_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;

    sel_e              dec_sel;
    logic [CH_W-1:0]   dec_idx;
    logic [DATA_W-1:0] ch_ld  [NUM_CH];
    logic [DATA_W-1:0] ch_bg  [NUM_CH];
    logic [DATA_W-1:0] ch_val [NUM_CH];
    ctrl_t             ch_ctl [NUM_CH];
    logic [NUM_CH-1:0] ch_uf;
    logic [NUM_CH-1:0] mask_q;
    logic [NUM_CH-1:0] raw_q;
    logic [NUM_CH-1:0] mis;

    tmr_addr_dec #(.ADDR_W(ADDR_W), .NUM_CH(NUM_CH), .CH_W(CH_W)) u_dec (
        .addr (bus_addr),
        .sel  (dec_sel),
        .idx  (dec_idx)
    );

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        logic hit;
        assign hit = bus_we && (dec_idx == CH_W'(g));
        tmr_chan u_chan (
            .clk    (clk),
            .rst    (rst),
            .tick   (tick),
            .ld_we  (hit && dec_sel == SEL_LOAD),
            .ctl_we (hit && dec_sel == SEL_CTL),
            .bg_we  (hit && dec_sel == SEL_BG),
            .wdata  (bus_wdata),
            .ld_q   (ch_ld[g]),
            .bg_q   (ch_bg[g]),
            .val    (ch_val[g]),
            .ctrl_q (ch_ctl[g]),
            .uf     (ch_uf[g])
        );
    end

    tmr_irq #(.NUM_CH(NUM_CH)) u_irq (
        .clk     (clk),
        .rst     (rst),
        .set     (ch_uf),
        .mask_we (bus_we && dec_sel == SEL_MASK),
        .clr_we  (bus_we && dec_sel == SEL_CLR),
        .wbits   (bus_wdata[NUM_CH-1:0]),
        .mask_q  (mask_q),
        .raw_q   (raw_q),
        .mis     (mis),
        .irq     (irq)
    );

    always_comb begin
        case (dec_sel)
            SEL_MASK: bus_rdata = {{(32-NUM_CH){1'b0}}, mask_q};
            SEL_RAW:  bus_rdata = {{(32-NUM_CH){1'b0}}, raw_q};
            SEL_MIS:  bus_rdata = {{(32-NUM_CH){1'b0}}, mis};
            SEL_LOAD: bus_rdata = ch_ld[dec_idx];
            SEL_VAL:  bus_rdata = ch_val[dec_idx];
            SEL_CTL:  bus_rdata = ctrl_to_word(ch_ctl[dec_idx]);
            SEL_BG:   bus_rdata = ch_bg[dec_idx];
            default:  bus_rdata = '0;
        endcase
    end

    AST_IRQ_NEEDS_RAW: assert property (@(posedge clk) disable iff (rst)
        irq |-> (raw_q != '0)); // R11
endmodule

// File: tb/sim_tmr_unit.sv
`timescale 1ns/1ps
module sim_tmr_unit;
    logic        clk = 1'b0;
    logic        rst;
    logic        tick;
    logic [7:0]  addr;
    logic [31:0] wdata;
    logic        we;
    logic [31:0] rdata;
    logic        irq;

    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    tmr_unit u0 (
        .clk       (clk),
        .rst       (rst),
        .tick      (tick),
        .bus_addr  (addr),
        .bus_wdata (wdata),
        .bus_we    (we),
        .bus_rdata (rdata),
        .irq       (irq)
    );

    function automatic logic [7:0] ch_a(input int n, input int sub);
        return 8'(16 + 16 * n + sub);
    endfunction

    function automatic logic [31:0] ctl_w(input bit en, input bit per,
                                          input int ps, input bit wide,
                                          input bit os);
        return {24'd0, en, per, 2'b00, 2'(ps), wide, os};
    endfunction

    function automatic int div_of(input int ps);
        return (ps == 1) ? 16 : (ps == 2) ? 256 : 1;
    endfunction

    task automatic chk(input string tag, input logic [31:0] got,
                       input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s got 0x%08h expected 0x%08h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        addr = a; wdata = d; we = 1'b1;
        @(posedge clk); #2;
        we = 1'b0;
    endtask

    task automatic rchk(input string tag, input logic [7:0] a,
                        input logic [31:0] exp);
        addr = a;
        #1;
        chk(tag, rdata, exp);
    endtask

    task automatic tk(input int n);
        tick = 1'b1;
        repeat (n) begin
            @(posedge clk); #2;
        end
        tick = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) begin
            @(posedge clk); #2;
        end
    endtask

    initial begin
        #2000000;
        fails++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        rst = 1'b1; tick = 1'b0; addr = '0; wdata = '0; we = 1'b0;
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        #2 rst = 1'b0;

        // R1 reset state
        rchk("R1 raw", 8'h04, 0);
        rchk("R1 mask", 8'h00, 0);
        rchk("R1 mis", 8'h08, 0);
        rchk("R1 ctrl", ch_a(0, 8), 0);
        rchk("R1 value", ch_a(0, 4), 0);
        rchk("R1 bg", ch_a(3, 12), 0);
        chk("R1 irq", {31'd0, irq}, 0);

        // R3 control layout, R2 map
        wr(ch_a(2, 8), 32'hFFFF_FFFF);
        rchk("R3 ctrl bits", ch_a(2, 8), 32'h0000_00CF);
        wr(ch_a(2, 8), 0);
        wr(ch_a(2, 0), 32'h0000_ABCD);
        rchk("R4 load readback", ch_a(2, 0), 32'h0000_ABCD);
        rchk("R4 load copies bg", ch_a(2, 12), 32'h0000_ABCD);
        wr(ch_a(2, 4), 32'h0000_1111);
        rchk("R2 value read-only", ch_a(2, 4), 32'h0000_ABCD);
        rchk("R2 unmapped", 8'h50, 0);
        rchk("R2 misaligned", 8'h31, 0);
        wr(8'h02, 32'hF);
        rchk("R2 misaligned write ignored", 8'h00, 0);
        rchk("R12 clear reads zero", 8'h0C, 0);

        // R4 / R5 load and enable
        wr(ch_a(0, 8), ctl_w(0, 0, 0, 1, 0));
        wr(ch_a(0, 0), 100);
        rchk("R4 load value", ch_a(0, 4), 100);
        tk(5);
        rchk("R5 disabled holds", ch_a(0, 4), 100);
        wr(ch_a(0, 8), ctl_w(1, 0, 0, 1, 0));
        tk(5);
        rchk("R5 counts down", ch_a(0, 4), 95);
        idle(4);
        rchk("R5 no tick holds", ch_a(0, 4), 95);

        // R6 prescaler
        wr(ch_a(0, 8), ctl_w(1, 0, 1, 1, 0));
        tk(div_of(1) - 1);
        rchk("R6 div16 short", ch_a(0, 4), 95);
        tk(1);
        rchk("R6 div16 step", ch_a(0, 4), 94);
        wr(ch_a(0, 8), ctl_w(1, 0, 2, 1, 0));
        tk(div_of(2) - 1);
        rchk("R6 div256 short", ch_a(0, 4), 94);
        tk(1);
        rchk("R6 div256 step", ch_a(0, 4), 93);
        wr(ch_a(0, 8), ctl_w(1, 0, 3, 1, 0));
        tk(3);
        rchk("R6 reserved code", ch_a(0, 4), 90);
        wr(ch_a(0, 8), ctl_w(1, 0, 1, 1, 0));
        tk(10);
        wr(ch_a(0, 0), 50);
        tk(15);
        rchk("R4 prescaler restart", ch_a(0, 4), 50);
        tk(1);
        rchk("R4 prescaler restart step", ch_a(0, 4), 49);

        // R7 16-bit width and free-running wrap, R8
        wr(ch_a(0, 8), ctl_w(1, 0, 0, 0, 0));
        wr(ch_a(0, 0), 32'h0001_2345);
        rchk("R7 16-bit load", ch_a(0, 4), 32'h0000_2345);
        wr(ch_a(0, 0), 1);
        tk(1);
        rchk("R8 reach zero", ch_a(0, 4), 0);
        rchk("R8 no underflow yet", 8'h04, 0);
        tk(1);
        rchk("R7 wrap 16", ch_a(0, 4), 32'h0000_FFFF);
        rchk("R11 raw set", 8'h04, 1);
        wr(8'h0C, 32'hF);
        wr(ch_a(0, 8), ctl_w(1, 0, 0, 1, 0));
        wr(ch_a(0, 0), 0);
        tk(1);
        rchk("R7 wrap 32", ch_a(0, 4), 32'hFFFF_FFFF);

        // R9 background reload in periodic mode
        wr(8'h0C, 32'hF);
        wr(ch_a(0, 8), ctl_w(1, 1, 0, 1, 0));
        wr(ch_a(0, 0), 3);
        wr(ch_a(0, 12), 10);
        rchk("R9 bg no disturb", ch_a(0, 4), 3);
        rchk("R9 bg readback", ch_a(0, 12), 10);
        tk(3);
        rchk("R9 at zero", ch_a(0, 4), 0);
        tk(1);
        rchk("R8 periodic reload", ch_a(0, 4), 10);
        rchk("R11 periodic raw", 8'h04, 1);
        tk(1);
        rchk("R8 after reload", ch_a(0, 4), 9);

        // R11 mask and irq
        wr(ch_a(0, 8), 0);
        wr(8'h0C, 32'hF);
        wr(8'h00, 0);
        wr(ch_a(1, 8), ctl_w(1, 1, 0, 1, 0));
        wr(ch_a(1, 0), 0);
        tk(1);
        rchk("R11 raw ch1", 8'h04, 2);
        rchk("R11 masked off", 8'h08, 0);
        chk("R11 irq masked", {31'd0, irq}, 0);
        wr(8'h00, 2);
        rchk("R11 mask readback", 8'h00, 2);
        rchk("R11 masked on", 8'h08, 2);
        chk("R11 irq high", {31'd0, irq}, 1);

        // R12 clear
        wr(8'h0C, 0);
        rchk("R12 zero write no effect", 8'h04, 2);
        wr(8'h0C, 1);
        rchk("R12 other bit no effect", 8'h04, 2);
        wr(8'h0C, 2);
        rchk("R12 cleared", 8'h04, 0);
        chk("R12 irq low", {31'd0, irq}, 0);
        addr = 8'h0C; wdata = 2; we = 1'b1; tick = 1'b1;
        @(posedge clk); #2;
        we = 1'b0; tick = 1'b0;
        rchk("R12 set beats clear", 8'h04, 2);
        chk("R12 irq after race", {31'd0, irq}, 1);
        wr(ch_a(1, 8), 0);
        wr(8'h0C, 32'hF);
        wr(8'h00, 0);

        // R10 one-shot
        wr(ch_a(1, 8), ctl_w(1, 0, 0, 1, 1));
        wr(ch_a(1, 0), 2);
        tk(2);
        rchk("R10 at zero", ch_a(1, 4), 0);
        rchk("R10 no status yet", 8'h04, 0);
        tk(1);
        rchk("R10 status", 8'h04, 2);
        rchk("R10 stays zero", ch_a(1, 4), 0);
        wr(8'h0C, 2);
        tk(3);
        rchk("R10 stopped value", ch_a(1, 4), 0);
        rchk("R10 stopped status", 8'h04, 0);
        wr(ch_a(1, 0), 5);
        tk(1);
        rchk("R10 restart by load", ch_a(1, 4), 4);
        wr(ch_a(1, 8), 0);

        // Random: R5 R6 R8 R11 on channel 3
        for (int t = 0; t < 20; t++) begin
            int ps;
            int ld;
            int m_val;
            int m_pre;
            int m_raw;
            ps = int'($urandom % 4);
            ld = 1 + int'($urandom % 30);
            wr(8'h0C, 32'hF);
            wr(ch_a(3, 8), ctl_w(1, 1, ps, 1, 0));
            wr(ch_a(3, 0), 32'(ld));
            m_val = ld; m_pre = 0; m_raw = 0;
            for (int c = 0; c < 600; c++) begin
                bit tb;
                tb = bit'($urandom % 2);
                tick = tb;
                @(posedge clk); #2;
                if (tb) begin
                    if (m_pre == div_of(ps) - 1) begin
                        m_pre = 0;
                        if (m_val == 0) begin
                            m_val = ld;
                            m_raw = 1;
                        end else begin
                            m_val--;
                        end
                    end else begin
                        m_pre++;
                    end
                end
            end
            tick = 1'b0;
            rchk("R6 random value", ch_a(3, 4), 32'(m_val));
            rchk("R8 random status", 8'h04, 32'(m_raw << 3));
        end
        wr(ch_a(3, 8), 0);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule